// File: doc/BRIEF.md
# Edge-Detecting GPIO Expander Core

This block is a bank of general-purpose lines, organised in 8-bit banks (three by default, 24 lines), with a byte-wide register port. Line n sits in bank n/8 at bit n%8. Each line has a direction bit that drives its output enable. Its output latch is changed only through a pair of write-one set and write-one clear registers. A monitor register returns the synchronized pin levels.

Each input passes through a two-flop synchronizer. Per-line rising and falling enables then select which transitions are recorded. A recorded transition sets an edge-status bit and an interrupt-status bit together. The host clears each of the two independently by writing ones. A single active-high interrupt output is raised while any interrupt-status bit with its interrupt enable set is 1.

Host accesses carry an optional address. An access without an address continues from the byte after the previous one, so a multi-byte register can be fetched as a burst. Every multi-byte register places its highest bank at its lowest address.

Top module: `gpio_xp_core`

## Requirements
- R1: Register groups are 3 bytes wide (one byte per bank) at base address group*3, with group codes MON=0, DIR=1, SET=2, CLR=3, RISE=4, FALL=5, IEN=6, ISTAT=7, EDGE=8. Byte base+k holds bank 2-k, so the top bank comes first. Reads of addresses 27 to 31 return 0.
- R2: An access with `host_addr_vld`=0 uses the address after the previous access (read or write). A burst read from a group base therefore returns the high, middle and low bank bytes in that order, and may cross into the next group.
- R3: A write to SET ORs the written byte into the output latch of that bank. A write to CLR clears the bits where the byte is 1. Zero bits leave the latch unchanged. SET and CLR both read back the latch. `pin_out` shows the latch, and `pin_oe` shows DIR, where 1 means output.
- R4: After synchronous reset, every register is 0, `pin_oe`, `pin_out` and `irq_out` are low, and every readable byte is 0 while the pins are low.
- R5: MON returns `pin_in` after a two-flop synchronizer. A read issued two or more cycles after a pin change sees the new level. Writes to MON have no effect.
- R6: A 0-to-1 transition on a line with its RISE bit set, or a 1-to-0 transition with its FALL bit set, sets that line's ISTAT and EDGE bits. With both bits set, either transition counts. With neither set, no status bit is set.
- R7: Writing 1 to an ISTAT or EDGE bit clears it, and writing 0 leaves it unchanged.
- R8: If a transition sets a status bit in the same cycle that a write-one clear targets it, the bit stays set.
- R9: `irq_out` is registered and equals the OR of ISTAT AND IEN one cycle earlier. A line with IEN=0 records status but does not raise the output.
- R10: ISTAT and EDGE are cleared independently, so clearing one leaves the other intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Byte address, used when host_addr_vld is 1 |
| host_addr_vld | input | 1 | 1: use host_addr; 0: continue after the last access |
| host_wr | input | 1 | Write strobe (takes precedence over host_rd) |
| host_rd | input | 1 | Read strobe; data appears on host_rdata after the next edge |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Registered read data byte |
| pin_in | input | 24 | Pin levels, asynchronous |
| pin_out | output | 24 | Output latch |
| pin_oe | output | 24 | Output enable per line (1 = output) |
| irq_out | output | 1 | Active-high combined interrupt |

## Verification
A corrupted enable, status or latch bit shows up within four cycles of a pin transition: either `irq_out` stays wrong after the registered stage, or a burst read of ISTAT or EDGE returns the wrong bit. A wrong pointer or bank decode reorders or shifts the bytes of a burst, so the fault is visible on the very next read. Every line is swept through all enable combinations and both transition directions. The cycle in which a clear collides with a new transition is hit exactly, so that a wrong priority leaves a 0 where a 1 is expected.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;
  // Register group codes; address = code * bank count + (bank count - 1 - bank)
  typedef enum logic [3:0] {
    GRP_MON   = 4'd0,
    GRP_DIR   = 4'd1,
    GRP_SET   = 4'd2,
    GRP_CLR   = 4'd3,
    GRP_RISE  = 4'd4,
    GRP_FALL  = 4'd5,
    GRP_IEN   = 4'd6,
    GRP_ISTAT = 4'd7,
    GRP_EDGE  = 4'd8
  } grp_e;

  localparam int GRP_COUNT = 9;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/gpio_xp_sync_edge.sv
module gpio_xp_sync_edge #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise_ev,
  output logic [W-1:0] fall_ev
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign level[i]   = s2_q;
    assign rise_ev[i] = s2_q & ~s3_q;
    assign fall_ev[i] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/gpio_xp_host_port.sv
module gpio_xp_host_port
  import gpio_xp_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 5,
  parameter int BANK_W    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [ADDR_W-1:0]                     host_addr,
  input  logic                                  host_addr_vld,
  input  logic                                  host_wr,
  input  logic                                  host_rd,
  input  logic [BYTE_W-1:0]                     host_wdata,
  input  logic [GRP_COUNT-1:0][NUM_BANKS*BYTE_W-1:0] rd_vec,
  output logic                                  wr_en,
  output logic [ADDR_W-1:0]                     wr_grp,
  output logic [BANK_W-1:0]                     wr_bank,
  output logic [BYTE_W-1:0]                     wr_data,
  output logic [BYTE_W-1:0]                     host_rdata
);
  localparam logic [ADDR_W-1:0] NB_A  = ADDR_W'(NUM_BANKS);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(GRP_COUNT * NUM_BANKS);

  logic [ADDR_W-1:0] ptr_q, eff_addr, grp_idx, slot_idx, bank_full;
  logic [BANK_W-1:0] bank_idx;
  logic              hit;
  logic [BYTE_W-1:0] rd_byte;

  assign eff_addr  = host_addr_vld ? host_addr : ptr_q;
  assign hit       = eff_addr < TOP_A;
  assign grp_idx   = eff_addr / NB_A;
  assign slot_idx  = eff_addr % NB_A;
  assign bank_full = NB_A - ADDR_W'(1) - slot_idx;
  assign bank_idx  = bank_full[BANK_W-1:0];

  assign wr_en   = host_wr && hit;
  assign wr_grp  = grp_idx;
  assign wr_bank = bank_idx;
  assign wr_data = host_wdata;

  always_comb begin
    rd_byte = '0;
    for (int g = 0; g < GRP_COUNT; g++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (hit && grp_idx == ADDR_W'(g) && bank_idx == BANK_W'(b))
          rd_byte = rd_vec[g][b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      host_rdata <= '0;
    end else begin
      if (host_rd || host_wr) ptr_q <= eff_addr + ADDR_W'(1);
      if (host_rd && !host_wr) host_rdata <= rd_byte;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (host_rd || host_wr) |=> (ptr_q == ADDR_W'($past(eff_addr) + ADDR_W'(1)))); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && !host_wr) |=> $stable(host_rdata)); // R2
endmodule

// File: rtl/gpio_xp_regfile.sv
module gpio_xp_regfile
  import gpio_xp_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 5,
  parameter int BANK_W    = 2
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       wr_en,
  input  logic [ADDR_W-1:0]                          wr_grp,
  input  logic [BANK_W-1:0]                          wr_bank,
  input  logic [BYTE_W-1:0]                          wr_data,
  input  logic [NUM_BANKS*BYTE_W-1:0]                level,
  input  logic [NUM_BANKS*BYTE_W-1:0]                rise_ev,
  input  logic [NUM_BANKS*BYTE_W-1:0]                fall_ev,
  output logic [GRP_COUNT-1:0][NUM_BANKS*BYTE_W-1:0] rd_vec,
  output logic [NUM_BANKS*BYTE_W-1:0]                out_q,
  output logic [NUM_BANKS*BYTE_W-1:0]                dir_q,
  output logic                                       irq_q
);
  localparam int W = NUM_BANKS * BYTE_W;

  logic [GRP_COUNT-1:0] grp_we;
  logic [W-1:0]         wmask, hits;
  logic [W-1:0]         rise_q, fall_q, ien_q, istat_q, edge_q;

  for (genvar g = 0; g < GRP_COUNT; g++) begin : g_grp_we
    assign grp_we[g] = wr_en && (wr_grp == ADDR_W'(g));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic lane;
    assign lane = (wr_bank == BANK_W'(b));
    assign wmask[b*BYTE_W +: BYTE_W] = lane ? wr_data : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q [b*BYTE_W +: BYTE_W] <= '0;
        rise_q[b*BYTE_W +: BYTE_W] <= '0;
        fall_q[b*BYTE_W +: BYTE_W] <= '0;
        ien_q [b*BYTE_W +: BYTE_W] <= '0;
      end else if (lane) begin
        if (grp_we[GRP_DIR])  dir_q [b*BYTE_W +: BYTE_W] <= wr_data;
        if (grp_we[GRP_RISE]) rise_q[b*BYTE_W +: BYTE_W] <= wr_data;
        if (grp_we[GRP_FALL]) fall_q[b*BYTE_W +: BYTE_W] <= wr_data;
        if (grp_we[GRP_IEN])  ien_q [b*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  assign hits = (rise_ev & rise_q) | (fall_ev & fall_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      istat_q <= '0;
      edge_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      out_q   <= (out_q | (grp_we[GRP_SET] ? wmask : '0))
                 & ~(grp_we[GRP_CLR] ? wmask : '0);
      istat_q <= (istat_q & ~(grp_we[GRP_ISTAT] ? wmask : '0)) | hits;
      edge_q  <= (edge_q  & ~(grp_we[GRP_EDGE]  ? wmask : '0)) | hits;
      irq_q   <= |(istat_q & ien_q);
    end
  end

  always_comb begin
    rd_vec            = '0;
    rd_vec[GRP_MON]   = level;
    rd_vec[GRP_DIR]   = dir_q;
    rd_vec[GRP_SET]   = out_q;
    rd_vec[GRP_CLR]   = out_q;
    rd_vec[GRP_RISE]  = rise_q;
    rd_vec[GRP_FALL]  = fall_q;
    rd_vec[GRP_IEN]   = ien_q;
    rd_vec[GRP_ISTAT] = istat_q;
    rd_vec[GRP_EDGE]  = edge_q;
  end

  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (|hits) |=> (((istat_q & $past(hits)) == $past(hits)) && ((edge_q & $past(hits)) == $past(hits)))); // R8
  AST_NO_SPURIOUS_STATUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((istat_q & ~$past(istat_q) & ~$past(hits)) == '0)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (grp_we[GRP_ISTAT] && !(|hits)) |=> ((istat_q & $past(wmask)) == '0)); // R7
  AST_EDGE_KEPT_ON_ISTAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (grp_we[GRP_ISTAT]) |=> ((edge_q & $past(edge_q)) == $past(edge_q))); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(grp_we[GRP_SET] || grp_we[GRP_CLR]) |=> $stable(out_q)); // R3
endmodule

// File: rtl/gpio_xp_core.sv
module gpio_xp_core
  import gpio_xp_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int W      = NUM_BANKS * BYTE_W,
  localparam int ADDR_W = $clog2(GRP_COUNT * NUM_BANKS),
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_addr_vld,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq_out
);
  logic [W-1:0]                level, rise_ev, fall_ev;
  logic [GRP_COUNT-1:0][W-1:0] rd_vec;
  logic                        wr_en;
  logic [ADDR_W-1:0]           wr_grp;
  logic [BANK_W-1:0]           wr_bank;
  logic [7:0]                  wr_data;

  gpio_xp_sync_edge #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  gpio_xp_host_port #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_port (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_addr_vld(host_addr_vld),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .rd_vec(rd_vec),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_bank(wr_bank), .wr_data(wr_data),
    .host_rdata(host_rdata)
  );

  gpio_xp_regfile #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_bank(wr_bank), .wr_data(wr_data),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rd_vec(rd_vec), .out_q(pin_out), .dir_q(pin_oe), .irq_q(irq_out)
  );

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(rd_vec[GRP_ISTAT] & rd_vec[GRP_IEN])))); // R9
endmodule

// File: tb/gpio_xp_core_tb.sv
`timescale 1ns/1ps
module gpio_xp_core_tb_top;
  localparam int GR_MON = 0, GR_DIR = 1, GR_SET = 2, GR_CLR = 3, GR_RISE = 4,
                 GR_FALL = 5, GR_IEN = 6, GR_ISTAT = 7, GR_EDGE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  host_addr = '0;
  logic        host_addr_vld = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe;
  logic        irq_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_xp_core dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_addr_vld(host_addr_vld),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_addr_vld = 1'b1; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr_vld = 1'b0;
  endtask

  task automatic rd1(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_addr_vld = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_addr_vld = 1'b0;
    d = host_rdata;
  endtask

  // Burst write of a 24-bit group: top bank byte first
  task automatic wr24(input int g, input logic [23:0] v);
    @(negedge clk);
    host_addr = 5'(g * 3); host_addr_vld = 1'b1; host_wr = 1'b1; host_wdata = v[23:16];
    @(negedge clk);
    host_addr_vld = 1'b0; host_wdata = v[15:8];
    @(negedge clk);
    host_wdata = v[7:0];
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd24(input int g, output logic [23:0] v);
    @(negedge clk);
    host_addr = 5'(g * 3); host_addr_vld = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    v[23:16] = host_rdata; host_addr_vld = 1'b0;
    @(negedge clk);
    v[15:8] = host_rdata;
    @(negedge clk);
    v[7:0] = host_rdata; host_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] v, m_out, s, c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4: reset state of pins, interrupt and every address
    chk("R4 pin_oe", 32'(pin_oe), 0);
    chk("R4 pin_out", 32'(pin_out), 0);
    chk("R4 irq_out", 32'(irq_out), 0);
    for (int a = 0; a < 32; a++) begin
      rd1(5'(a), b);
      chk($sformatf("R4/R1 reset read addr %0d", a), 32'(b), 0);
    end

    // R1: byte placement, top bank at lowest address
    wr24(GR_DIR, 24'hA1B2C3);
    chk("R3 pin_oe from DIR", 32'(pin_oe), 32'hA1B2C3);
    rd1(5'(GR_DIR * 3 + 0), b); chk("R1 DIR high bank", 32'(b), 32'hA1);
    rd1(5'(GR_DIR * 3 + 1), b); chk("R1 DIR mid bank", 32'(b), 32'hB2);
    rd1(5'(GR_DIR * 3 + 2), b); chk("R1 DIR low bank", 32'(b), 32'hC3);
    wr1(5'(GR_DIR * 3 + 2), 8'h5E);
    chk("R1 single-byte DIR write", 32'(pin_oe), 32'hA1B25E);
    rd24(GR_DIR, v); chk("R2 burst DIR", 32'(v), 32'hA1B25E);

    // R2: burst crossing a group boundary (DIR low -> SET high)
    wr24(GR_SET, 24'h9900FF);
    m_out = 24'h9900FF;
    @(negedge clk);
    host_addr = 5'(GR_DIR * 3 + 2); host_addr_vld = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    b = host_rdata; host_addr_vld = 1'b0;
    chk("R2 cross first", 32'(b), 32'h5E);
    @(negedge clk);
    b = host_rdata; host_rd = 1'b0;
    chk("R2 cross second", 32'(b), 32'h99);

    // R3: set/clear sweep with arithmetic patterns
    for (int i = 0; i < 16; i++) begin
      s = 24'((i * 32'h3B5A71 + 32'h1234) & 32'hFFFFFF);
      c = 24'((i * 32'h5C3E17) & 32'hFFFFFF);
      wr24(GR_SET, s); m_out = m_out | s;
      chk($sformatf("R3 set step %0d", i), 32'(pin_out), 32'(m_out));
      wr24(GR_CLR, c); m_out = m_out & ~c;
      chk($sformatf("R3 clr step %0d", i), 32'(pin_out), 32'(m_out));
    end
    wr24(GR_SET, 24'h0); wr24(GR_CLR, 24'h0);
    chk("R3 zero writes keep latch", 32'(pin_out), 32'(m_out));
    rd24(GR_CLR, v); chk("R3 CLR reads latch", 32'(v), 32'(m_out));
    rd24(GR_SET, v); chk("R3 SET reads latch", 32'(v), 32'(m_out));

    // R5: monitor after two-flop synchronizer
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pin_in = 24'((i * 32'h2D4F1B + 32'h0F0F) & 32'hFFFFFF);
      idle(1);
      rd24(GR_MON, v);
      chk($sformatf("R5 monitor pattern %0d", i), 32'(v), 32'(pin_in));
    end
    pin_in = 24'h123456; idle(3);
    wr24(GR_MON, 24'hFFFFFF);
    rd24(GR_MON, v); chk("R5 MON write ignored", 32'(v), 32'h123456);
    chk("R5 MON write no side effect on latch", 32'(pin_out), 32'(m_out));
    pin_in = '0; idle(4);
    wr24(GR_ISTAT, 24'hFFFFFF); wr24(GR_EDGE, 24'hFFFFFF);

    // R6/R9: every line, every enable combination, both directions
    for (int l = 0; l < 24; l++) begin
      for (int cmb = 0; cmb < 4; cmb++) begin
        for (int d = 0; d < 2; d++) begin
          logic [23:0] bit_l, expv;
          bit_l = 24'(1) << l;
          pin_in = (d == 0) ? 24'h0 : bit_l;
          idle(4);
          wr24(GR_RISE, (cmb & 1) != 0 ? bit_l : 24'h0);
          wr24(GR_FALL, (cmb & 2) != 0 ? bit_l : 24'h0);
          wr24(GR_IEN, bit_l);
          wr24(GR_ISTAT, 24'hFFFFFF);
          wr24(GR_EDGE, 24'hFFFFFF);
          @(negedge clk);
          pin_in = pin_in ^ bit_l;
          idle(4);
          expv = ((d == 0 && (cmb & 1) != 0) || (d == 1 && (cmb & 2) != 0)) ? bit_l : 24'h0;
          chk($sformatf("R9 irq line %0d en %0d dir %0d", l, cmb, d), 32'(irq_out), 32'(expv != 0));
          rd24(GR_ISTAT, v);
          chk($sformatf("R6 istat line %0d en %0d dir %0d", l, cmb, d), 32'(v), 32'(expv));
          rd24(GR_EDGE, v);
          chk($sformatf("R6 edge line %0d en %0d dir %0d", l, cmb, d), 32'(v), 32'(expv));
        end
      end
    end

    // R9: status recorded but interrupt masked
    pin_in = '0; idle(4);
    wr24(GR_RISE, 24'h000020); wr24(GR_FALL, 24'h0); wr24(GR_IEN, 24'h0);
    wr24(GR_ISTAT, 24'hFFFFFF);
    @(negedge clk); pin_in = 24'h000020; idle(4);
    chk("R9 masked line irq low", 32'(irq_out), 0);
    rd24(GR_ISTAT, v); chk("R9 masked line status set", 32'(v), 32'h20);

    // R7/R10: write-one-to-clear and independent clears
    pin_in = '0; idle(4);
    wr24(GR_RISE, 24'hFFFFFF); wr24(GR_IEN, 24'hFFFFFF);
    wr24(GR_ISTAT, 24'hFFFFFF); wr24(GR_EDGE, 24'hFFFFFF);
    @(negedge clk); pin_in = 24'hFFFFFF; idle(4);
    chk("R9 irq all lines", 32'(irq_out), 1);
    wr24(GR_ISTAT, 24'h0);
    rd24(GR_ISTAT, v); chk("R7 zero write keeps istat", 32'(v), 32'hFFFFFF);
    wr24(GR_ISTAT, 24'h0F00F0);
    rd24(GR_ISTAT, v); chk("R7 partial clear istat", 32'(v), 32'hF0FF0F);
    rd24(GR_EDGE, v); chk("R10 edge kept on istat clear", 32'(v), 32'hFFFFFF);
    wr24(GR_EDGE, 24'hFFFFFF);
    rd24(GR_EDGE, v); chk("R7 edge cleared", 32'(v), 32'h0);
    rd24(GR_ISTAT, v); chk("R10 istat kept on edge clear", 32'(v), 32'hF0FF0F);
    chk("R9 irq still high", 32'(irq_out), 1);
    wr24(GR_ISTAT, 24'hFFFFFF); idle(1);
    chk("R9 irq low after clear", 32'(irq_out), 0);

    // R8: clear colliding with a new transition on line 0
    pin_in = '0; idle(4);
    wr24(GR_RISE, 24'h000001); wr24(GR_ISTAT, 24'hFFFFFF); wr24(GR_EDGE, 24'hFFFFFF);
    @(negedge clk); pin_in = 24'h000001;
    @(negedge clk);
    @(negedge clk);
    host_addr = 5'(GR_ISTAT * 3 + 2); host_addr_vld = 1'b1; host_wr = 1'b1; host_wdata = 8'h01;
    @(negedge clk);
    host_wr = 1'b0; host_addr_vld = 1'b0;
    rd24(GR_ISTAT, v); chk("R8 transition wins over clear", 32'(v), 32'h1);
    pin_in = '0; idle(4);
    wr24(GR_ISTAT, 24'hFFFFFF);
    @(negedge clk); pin_in = 24'h000001;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    host_addr = 5'(GR_ISTAT * 3 + 2); host_addr_vld = 1'b1; host_wr = 1'b1; host_wdata = 8'h01;
    @(negedge clk);
    host_wr = 1'b0; host_addr_vld = 1'b0;
    rd24(GR_ISTAT, v); chk("R8 clear one cycle later removes bit", 32'(v), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule